// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events from 41 sources (fifteen external request lines, one non-maskable input and twenty-five on-chip peripheral events) and keeps a set of those still waiting for service. From that set it picks one winner. The winner is the source with the highest priority, and lower source index breaks ties. The block presents the winner's 12-bit exception code to the CPU. It asserts a request line only while the CPU's block bit is clear and the CPU's current 4-bit mask is strictly below the winner's priority.

The external lines and the non-maskable input have fixed priorities. Three 16-bit configuration registers set the peripheral priorities. Each register holds four 4-bit fields, and one field may set the level of several sources at once. A priority of zero masks a source: raising it leaves nothing behind. When the CPU takes the interrupt it pulses an accept strobe. The winner then leaves the pending set, and the code and request are recomputed from the sources that remain.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending set is empty: `intr_valid` and `intr_req` are 0, `intr_code` is 0, and all three configuration registers read 0, so every peripheral source is masked.
- R2: External line k (0..14, input `ext_irq[k]`) has fixed priority 15-k and exception code 0x200 + 0x20*k.
- R3: The non-maskable input has priority 16 and code 0x1C0. It requests the CPU whenever the block bit is clear, even with mask 15.
- R4: Peripheral bit p of `periph_irq` is source 16+p. The exception codes are: p=0 0x600, p=1 0x620, p=2..6 0x640..0x6C0, p=7..17 0x400..0x540, p=18..21 0x700..0x760, p=22..24 0x560..0x5A0, all in steps of 0x20.
- R5: Register 0 (address 0) fields [15:12], [11:8], [7:4] and [3:0] set p=7, p=8, p=9..10 and p=11..13. Register 1 fields [15:12], [11:8] and [7:4] set p=22, p=23..24 and p=14..17. Register 2 fields [15:12], [11:8], [7:4] and [3:0] set p=1, p=2..6, p=18..21 and p=0.
- R6: Bits [3:0] of register 1 set no priority. A read from any of addresses 0..2 returns the last value written there, reserved bits included. Address 3 reads 0 and ignores writes.
- R7: Raising a source whose current priority is 0 has no effect. It does not become pending, even if its priority is raised later.
- R8: Raising a source that is already pending changes nothing. A single accept retires it.
- R9: The winner is the pending source with the highest priority. On equal priority the lower source index wins.
- R10: `intr_req` is 1 exactly when a winner exists, `cpu_block` is 0 and `cpu_mask` is strictly below the winner's priority. It follows changes of mask and block in the same cycle.
- R11: An `ack` pulse while `intr_valid` is 1 removes the winner shown in that cycle. From the next cycle the code and request reflect the sources that remain. An `ack` with no winner has no effect.
- R12: A raise in the same cycle as an accept is recorded, including a raise of the source being accepted, which then stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 15 | External request lines, bit k is source k |
| nmi_irq | input | 1 | Non-maskable request, source 15 |
| periph_irq | input | 25 | Peripheral events, bit p is source 16+p |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data for `cfg_addr` |
| cpu_block | input | 1 | CPU block bit, 1 suppresses the request |
| cpu_mask | input | 4 | CPU current interrupt mask |
| ack | input | 1 | Accept strobe from the CPU |
| intr_valid | output | 1 | A winner exists |
| intr_code | output | 12 | Exception code of the winner, 0 when none |
| intr_req | output | 1 | Interrupt request to the CPU |

## Verification
Two functions can land in the same cycle: an accept that retires the winner and a raise that adds a source. The bench provokes this by holding a pending source, then driving `ack` together with a raise of a lower-priority source, and separately together with a raise of the very source being retired. It judges the result by the code shown in the following cycle: the raised lower source in the first case, and the retired source still present in the second. A further case raises two sources of equal priority in one cycle and checks that accepts release them in index order.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_EXT = 15,
  parameter int N_PER = 25,
  parameter int PW    = 4,
  parameter int CW    = 12,
  parameter int RW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [14:0]   ext_irq,
  input  logic          nmi_irq,
  input  logic [24:0]   periph_irq,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          cpu_block,
  input  logic [3:0]    cpu_mask,
  input  logic          ack,
  output logic          intr_valid,
  output logic [11:0]   intr_code,
  output logic          intr_req
);
  localparam int NS  = N_EXT + 1 + N_PER;
  localparam int NMI = N_EXT;
  localparam int P0  = N_EXT + 1;
  localparam int EPW = PW + 1;
  localparam int IW  = $clog2(NS);

  logic [RW-1:0]  preg [3];
  logic [NS-1:0]  pend;
  logic [NS-1:0]  raise_all;
  logic [NS-1:0]  set_v;
  logic [NS-1:0]  clr_v;
  logic [EPW-1:0] prio [NS];
  logic [EPW-1:0] win_prio;
  logic [IW-1:0]  win_idx;

  function automatic logic [CW-1:0] code_of(input int i);
    int p;
    p = i - P0;
    if (i < N_EXT)    return CW'(12'h200 + 12'h20 * i);
    else if (i == NMI) return CW'(12'h1C0);
    else if (p < 7)   return CW'(12'h600 + 12'h20 * p);
    else if (p < 18)  return CW'(12'h400 + 12'h20 * (p - 7));
    else if (p < 22)  return CW'(12'h700 + 12'h20 * (p - 18));
    else              return CW'(12'h560 + 12'h20 * (p - 22));
  endfunction

  function automatic logic [EPW-1:0] fld(input logic [RW-1:0] r, input int f);
    return {1'b0, r[f*PW +: PW]};
  endfunction

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      int p;
      p = i - P0;
      if (i < N_EXT)     prio[i] = EPW'(N_EXT - i);
      else if (i == NMI) prio[i] = EPW'(16);
      else if (p == 0)   prio[i] = fld(preg[2], 0);
      else if (p == 1)   prio[i] = fld(preg[2], 3);
      else if (p < 7)    prio[i] = fld(preg[2], 2);
      else if (p == 7)   prio[i] = fld(preg[0], 3);
      else if (p == 8)   prio[i] = fld(preg[0], 2);
      else if (p < 11)   prio[i] = fld(preg[0], 1);
      else if (p < 14)   prio[i] = fld(preg[0], 0);
      else if (p < 18)   prio[i] = fld(preg[1], 1);
      else if (p < 22)   prio[i] = fld(preg[2], 1);
      else if (p == 22)  prio[i] = fld(preg[1], 3);
      else               prio[i] = fld(preg[1], 2);
    end
  end

  always_comb begin
    win_prio = '0;
    win_idx  = '0;
    for (int i = 0; i < NS; i++)
      if (pend[i] && prio[i] > win_prio) begin
        win_prio = prio[i];
        win_idx  = IW'(i);
      end
  end

  assign raise_all  = {periph_irq, nmi_irq, ext_irq};
  assign intr_valid = (win_prio != '0);
  assign intr_code  = intr_valid ? code_of(int'(win_idx)) : '0;
  assign intr_req   = intr_valid && !cpu_block && ({1'b0, cpu_mask} < win_prio);
  assign cfg_rdata  = (cfg_addr == 2'd3) ? '0 : preg[cfg_addr];

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      set_v[i] = raise_all[i] && (prio[i] != '0);
      clr_v[i] = ack && intr_valid && (win_idx == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      for (int r = 0; r < 3; r++) preg[r] <= '0;
    end else begin
      pend <= (pend & ~clr_v) | set_v;
      if (cfg_we && cfg_addr != 2'd3) preg[cfg_addr] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [40:0] pend,
  input logic [40:0] raise_all,
  input logic [4:0]  win_prio,
  input logic        cpu_block,
  input logic [3:0]  cpu_mask,
  input logic        ack,
  input logic        intr_valid,
  input logic [11:0] intr_code,
  input logic        intr_req
);
  a_r10_req_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
    intr_req |-> (!cpu_block && intr_valid));
  a_r10_req_mask: assert property (@(posedge clk) disable iff (!rst_n)
    intr_req |-> ({1'b0, cpu_mask} < win_prio));
  a_r3_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[15] && !cpu_block) |-> (intr_req && intr_code == 12'h1C0));
  a_r11_ack_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && intr_valid && raise_all == '0) |=> ($countones(pend) == $past($countones(pend)) - 1));
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && raise_all == '0) |=> $stable(pend));
  a_r2_code_align: assert property (@(posedge clk) disable iff (!rst_n)
    intr_valid |-> (intr_code[4:0] == 5'd0 && intr_code != 12'd0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .raise_all(raise_all),
  .win_prio(win_prio), .cpu_block(cpu_block), .cpu_mask(cpu_mask),
  .ack(ack), .intr_valid(intr_valid), .intr_code(intr_code), .intr_req(intr_req)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [40:0] rv = '0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic cpu_block = 0; logic [3:0] cpu_mask = 0; logic ack = 0;
  logic intr_valid, intr_req; logic [11:0] intr_code;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_irq(rv[14:0]), .nmi_irq(rv[15]),
    .periph_irq(rv[40:16]), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_block(cpu_block),
    .cpu_mask(cpu_mask), .ack(ack), .intr_valid(intr_valid),
    .intr_code(intr_code), .intr_req(intr_req));

  // {source, code, priority} with registers 0x1234, 0x5670, 0x9ABC
  localparam logic [22:0] VEC [0:40] = '{
    {6'd0,12'h200,5'd15}, {6'd1,12'h220,5'd14}, {6'd2,12'h240,5'd13},
    {6'd3,12'h260,5'd12}, {6'd4,12'h280,5'd11}, {6'd5,12'h2A0,5'd10},
    {6'd6,12'h2C0,5'd9},  {6'd7,12'h2E0,5'd8},  {6'd8,12'h300,5'd7},
    {6'd9,12'h320,5'd6},  {6'd10,12'h340,5'd5}, {6'd11,12'h360,5'd4},
    {6'd12,12'h380,5'd3}, {6'd13,12'h3A0,5'd2}, {6'd14,12'h3C0,5'd1},
    {6'd15,12'h1C0,5'd16},{6'd16,12'h600,5'd12},{6'd17,12'h620,5'd9},
    {6'd18,12'h640,5'd10},{6'd19,12'h660,5'd10},{6'd20,12'h680,5'd10},
    {6'd21,12'h6A0,5'd10},{6'd22,12'h6C0,5'd10},{6'd23,12'h400,5'd1},
    {6'd24,12'h420,5'd2}, {6'd25,12'h440,5'd3}, {6'd26,12'h460,5'd3},
    {6'd27,12'h480,5'd4}, {6'd28,12'h4A0,5'd4}, {6'd29,12'h4C0,5'd4},
    {6'd30,12'h4E0,5'd7}, {6'd31,12'h500,5'd7}, {6'd32,12'h520,5'd7},
    {6'd33,12'h540,5'd7}, {6'd34,12'h700,5'd11},{6'd35,12'h720,5'd11},
    {6'd36,12'h740,5'd11},{6'd37,12'h760,5'd11},{6'd38,12'h560,5'd5},
    {6'd39,12'h580,5'd6}, {6'd40,12'h5A0,5'd6}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [40:0] v, input logic a);
    @(negedge clk); rv = v; ack = a;
    @(negedge clk); rv = '0; ack = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [15:0] exp);
    cfg_addr = a; #1; chk(tag, cfg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", intr_valid, 0); chk("R1 req", intr_req, 0); chk("R1 code", intr_code, 0);
    rd("R1 reg0", 0, 0); rd("R1 reg1", 1, 0); rd("R1 reg2", 2, 0);
    rst_n = 1;
    pulse(41'd1 << 16, 0);
    chk("R1 peripheral masked at reset", intr_valid, 0);

    wr(0, 16'h1234); wr(1, 16'h5670); wr(2, 16'h9ABC);
    rd("R6 reg0", 0, 16'h1234); rd("R6 reg1", 1, 16'h5670); rd("R6 reg2", 2, 16'h9ABC);
    wr(3, 16'hFFFF); rd("R6 addr3", 3, 0); rd("R6 reg0 untouched", 0, 16'h1234);

    for (int k = 0; k < 41; k++) begin
      int src; logic [11:0] code; logic [4:0] pr;
      {src, code, pr} = {26'd0, VEC[k]};
      cpu_mask = 0; cpu_block = 0;
      pulse(41'd1 << src, 0);
      chk($sformatf("R2 R3 R4 R5 code src%0d", src), intr_code, code);
      if (pr <= 15) begin
        cpu_mask = pr[3:0]; #1;
        chk($sformatf("R10 mask equal src%0d", src), intr_req, 0);
      end
      cpu_mask = 4'(pr - 1); #1;
      chk($sformatf("R10 mask below src%0d", src), intr_req, 1);
      pulse('0, 1);
      chk($sformatf("R11 retired src%0d", src), intr_valid, 0);
    end

    cpu_mask = 4'd15;
    pulse(41'd1 << 15, 0);
    chk("R3 nmi mask15", intr_req, 1);
    cpu_block = 1; #1; chk("R3 R10 block", intr_req, 0);
    cpu_block = 0; #1; chk("R10 unblock", intr_req, 1);
    pulse('0, 1); cpu_mask = 0;

    wr(2, 16'h9AB0);
    pulse(41'd1 << 16, 0);
    chk("R7 zero prio raise", intr_valid, 0);
    wr(2, 16'h9ABC); #1;
    chk("R7 still not pending", intr_valid, 0);

    wr(1, 16'h000F); rd("R6 reserved readback", 1, 16'h000F);
    pulse(41'd1 << 30, 0);
    chk("R6 reserved field assigns nothing", intr_valid, 0);
    wr(1, 16'h5670);

    pulse(41'd1 << 3, 0); pulse(41'd1 << 3, 0);
    pulse('0, 1);
    chk("R8 single accept", intr_valid, 0);

    pulse((41'd1 << 2) | (41'd1 << 5), 0);
    chk("R9 higher prio", intr_code, 12'h240);
    pulse('0, 1); chk("R9 next", intr_code, 12'h2A0);
    pulse('0, 1);
    pulse((41'd1 << 20) | (41'd1 << 18), 0);
    chk("R9 tie lower index", intr_code, 12'h640);
    pulse('0, 1); chk("R9 tie second", intr_code, 12'h680);
    pulse('0, 1); chk("R11 empty", intr_valid, 0);
    pulse('0, 1); chk("R11 ack with no winner", intr_valid, 0);

    pulse(41'd1 << 5, 0);
    pulse(41'd1 << 7, 1);
    chk("R12 raise during accept", intr_code, 12'h2E0);
    pulse('0, 1);
    pulse(41'd1 << 5, 0);
    pulse(41'd1 << 5, 1);
    chk("R12 same source stays", intr_code, 12'h2A0);
    pulse('0, 1); chk("R12 then retired", intr_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule